// File: doc/BRIEF.md
# AC-link Output Frame Receiver

This block is the codec-side deserializer for the stream a controller sends down an AC-link. It runs on the serial bit clock and samples both the frame marker (`sync_in`) and the serial data (`sdata_in`) on the falling edge. A frame starts on a sampled low-to-high change of the marker. The block then walks a fixed 256-bit frame. The frame begins with a 16-bit header: a frame-valid flag, twelve per-slot valid tags and three unused bits. Twelve 20-bit data slots follow, each sent MSB first.

Each completed slot word comes out on a parallel bus with its slot number and a one-cycle strobe. A word is delivered only when both the frame-valid flag and that slot's tag are set. This is how streams slower than the fixed frame rate skip frames. The header is also published as a 13-bit status word once per frame. A marker rise that cuts a frame short resynchronizes the receiver and pulses an error flag.

Top module: `acl_out_frame_rx`

## Requirements
- R1: `sync_in` and `sdata_in` are sampled on falling edges of `bit_clk`. A frame start is a falling edge that samples `sync_in` high after the previous falling edge sampled it low. A marker held high through reset release does not start a frame.
- R2: The first `sdata_in` bit after the start-detecting edge is the frame-valid flag. The next 12 bits are the tags of slots 1 to 12 in that order, followed by 3 ignored header bits. Twelve 20-bit slots then follow, for 256 bits per frame.
- R3: `frame_tags` holds the header of the most recent frame. Bit 12 is the frame-valid flag and bit (12-k) is the tag of slot k. It changes only on the falling edge that samples header bit 15.
- R4: Each slot is assembled MSB first. After the edge that samples a slot's 20th bit, `slot_word` carries the word and `slot_num` carries the slot number (1 to 12), and `slot_stb` is high for exactly one bit-clock period.
- R5: `slot_stb` is raised for slot k only if the frame-valid flag and the slot k tag of the current frame are both 1. Otherwise the slot is consumed and no strobe is issued.
- R6: While `rst_n` is low all outputs are 0. No strobe is issued and `frame_tags` stays 0 until a frame start has been detected.
- R7: A frame start detected before all 256 bits of the running frame have been sampled restarts the frame at bit 0. It also raises `frame_err` for one bit-clock period. A start detected on the edge that samples bit 255, or while no frame is running, raises no error.
- R8: After bit 255 with no new start, the receiver idles. Further data issues no strobe and leaves `frame_tags` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Serial bit clock; all sampling on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_in | input | 1 | Frame marker from the controller |
| sdata_in | input | 1 | Serial frame data from the controller |
| slot_stb | output | 1 | One-cycle strobe for a delivered slot word |
| slot_num | output | 4 | Number (1..12) of the delivered slot |
| slot_word | output | 20 | Delivered slot word |
| frame_tags | output | 13 | Frame-valid flag (bit 12) and slot tags (bits 11..0) |
| frame_err | output | 1 | One-cycle pulse on a premature frame start |

## Verification
Back-to-back frames cover several header patterns: all tags set, tags set with the frame flag clear, the two alternating tag masks, only the first slot, only the last slot, and the flag set with no tags. Together these separate a correct tag-to-slot mapping from mirrored or shifted ones, and show whether the frame flag really gates delivery. Each slot carries a distinct word, so a bit-order or off-by-one alignment fault shows up in the data. A frame cut short at bit 100 tells a premature marker rise apart from the regular rise on bit 255 and from a rise after an idle gap. A marker held high across reset and long stretches of unframed data show that nothing is delivered without a real start.

// File: rtl/acl_rx_pkg.sv
package acl_rx_pkg;
  localparam int DEF_SLOT_W    = 20;
  localparam int DEF_NUM_SLOTS = 12;
  localparam int DEF_HDR_W     = 16;

  function automatic int frame_bits(input int hdr_w, input int slot_w, input int num_slots);
    return hdr_w + slot_w * num_slots;
  endfunction
endpackage

// File: rtl/acl_rst_sync.sv
module acl_rst_sync (
  input  logic clk_n,
  input  logic arst_n,
  output logic srst_n
);
  logic [1:0] stage_q;

  always_ff @(negedge clk_n or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n = stage_q[1];
endmodule

// File: rtl/acl_frame_track.sv
module acl_frame_track #(
  parameter int HDR_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int CNT_W     = 8
) (
  input  logic             bit_clk,
  input  logic             rst_n,
  input  logic             sync_i,
  output logic             bit_vld_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             frame_err_o
);
  localparam int             FRAME_BITS = HDR_W + SLOT_W * NUM_SLOTS;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic             sync_prev_q, sync_prev_d;
  logic             active_q, active_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             rise;

  always_comb begin
    rise        = sync_i & ~sync_prev_q;
    sync_prev_d = sync_i;
    active_d    = active_q;
    cnt_d       = cnt_q;
    err_d       = 1'b0;
    if (rise) begin
      active_d = 1'b1;
      cnt_d    = '0;
      err_d    = active_q && (cnt_q != LAST_IDX);
    end else if (active_q) begin
      if (cnt_q == LAST_IDX) begin
        active_d = 1'b0;
        cnt_d    = '0;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  // marker history resets high so a marker already high is not a rise
  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_prev_q <= 1'b1;
      active_q    <= 1'b0;
      cnt_q       <= '0;
      err_q       <= 1'b0;
    end else begin
      sync_prev_q <= sync_prev_d;
      active_q    <= active_d;
      cnt_q       <= cnt_d;
      err_q       <= err_d;
    end
  end

  assign bit_vld_o   = active_q;
  assign bit_idx_o   = cnt_q;
  assign frame_err_o = err_q;

  assert_err_single_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_err_o |=> !frame_err_o);
  assert_err_restart_R7: assert property (@(negedge bit_clk) disable iff (!rst_n)
    frame_err_o |-> (bit_vld_o && bit_idx_o == '0));
  assert_idle_after_full_R8: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (bit_vld_o && bit_idx_o == LAST_IDX && !sync_i) |=> !bit_vld_o);
endmodule

// File: rtl/acl_hdr_capture.sv
module acl_hdr_capture #(
  parameter int HDR_W     = 16,
  parameter int NUM_SLOTS = 12,
  parameter int CNT_W     = 8
) (
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               bit_vld_i,
  input  logic [CNT_W-1:0]   bit_idx_i,
  input  logic               sdata_i,
  output logic [NUM_SLOTS:0] tags_o
);
  localparam int TAG_W = NUM_SLOTS + 1;

  logic [TAG_W-1:0] sh_q, sh_d;
  logic [TAG_W-1:0] tags_q, tags_d;
  logic             shift_en, publish_en;

  always_comb begin
    shift_en   = bit_vld_i && (bit_idx_i < CNT_W'(TAG_W));
    publish_en = bit_vld_i && (bit_idx_i == CNT_W'(HDR_W - 1));
    sh_d       = sh_q;
    tags_d     = tags_q;
    if (shift_en)   sh_d   = {sh_q[TAG_W-2:0], sdata_i};
    if (publish_en) tags_d = sh_q;
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      tags_q <= '0;
    end else begin
      sh_q   <= sh_d;
      tags_q <= tags_d;
    end
  end

  assign tags_o = tags_q;

  assert_tags_hold_R3: assert property (@(negedge bit_clk) disable iff (!rst_n)
    !(bit_vld_i && bit_idx_i == CNT_W'(HDR_W - 1)) |=> $stable(tags_o));
endmodule

// File: rtl/acl_slot_deser.sv
module acl_slot_deser #(
  parameter int HDR_W     = 16,
  parameter int SLOT_W    = 20,
  parameter int NUM_SLOTS = 12,
  parameter int CNT_W     = 8
) (
  input  logic                           bit_clk,
  input  logic                           rst_n,
  input  logic                           bit_vld_i,
  input  logic [CNT_W-1:0]               bit_idx_i,
  input  logic                           sdata_i,
  input  logic [NUM_SLOTS:0]             tags_i,
  output logic                           slot_stb_o,
  output logic [$clog2(NUM_SLOTS+1)-1:0] slot_num_o,
  output logic [SLOT_W-1:0]              slot_word_o
);
  localparam int SB_W       = $clog2(SLOT_W);
  localparam int SNUM_W     = $clog2(NUM_SLOTS + 1);
  localparam int FRAME_BITS = HDR_W + SLOT_W * NUM_SLOTS;

  logic [SLOT_W-2:0] sh_q, sh_d;
  logic [SB_W-1:0]   sb_q, sb_d;
  logic [SNUM_W-1:0] sn_q, sn_d;
  logic              stb_q, stb_d;
  logic [SNUM_W-1:0] num_q, num_d;
  logic [SLOT_W-1:0] word_q, word_d;
  logic              hdr_end, in_slot, slot_tag;

  function automatic logic tag_at(input logic [NUM_SLOTS:0] t, input logic [SNUM_W-1:0] n);
    logic r;
    r = 1'b0;
    for (int k = 1; k <= NUM_SLOTS; k++)
      if (n == SNUM_W'(k)) r = t[NUM_SLOTS-k];
    return r;
  endfunction

  always_comb begin
    hdr_end  = bit_vld_i && (bit_idx_i == CNT_W'(HDR_W - 1));
    in_slot  = bit_vld_i && (bit_idx_i >= CNT_W'(HDR_W));
    slot_tag = tag_at(tags_i, sn_q);
    sh_d     = sh_q;
    sb_d     = sb_q;
    sn_d     = sn_q;
    stb_d    = 1'b0;
    num_d    = num_q;
    word_d   = word_q;
    if (hdr_end) begin
      sb_d = '0;
      sn_d = SNUM_W'(1);
    end else if (in_slot) begin
      sh_d = {sh_q[SLOT_W-3:0], sdata_i};
      if (sb_q == SB_W'(SLOT_W - 1)) begin
        sb_d = '0;
        if (sn_q != SNUM_W'(NUM_SLOTS)) sn_d = sn_q + SNUM_W'(1);
        if (tags_i[NUM_SLOTS] && slot_tag) begin
          stb_d  = 1'b1;
          num_d  = sn_q;
          word_d = {sh_q, sdata_i};
        end
      end else begin
        sb_d = sb_q + SB_W'(1);
      end
    end
  end

  always_ff @(negedge bit_clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      sb_q   <= '0;
      sn_q   <= '0;
      stb_q  <= 1'b0;
      num_q  <= '0;
      word_q <= '0;
    end else begin
      sh_q   <= sh_d;
      sb_q   <= sb_d;
      sn_q   <= sn_d;
      stb_q  <= stb_d;
      num_q  <= num_d;
      word_q <= word_d;
    end
  end

  assign slot_stb_o  = stb_q;
  assign slot_num_o  = num_q;
  assign slot_word_o = word_q;

  assert_stb_gated_R5: assert property (@(negedge bit_clk) disable iff (!rst_n)
    slot_stb_o |-> (tags_i[NUM_SLOTS] && tag_at(tags_i, slot_num_o)));
  assert_stb_single_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    slot_stb_o |=> !slot_stb_o);
  assert_num_range_R4: assert property (@(negedge bit_clk) disable iff (!rst_n)
    slot_stb_o |-> (slot_num_o >= SNUM_W'(1) && slot_num_o <= SNUM_W'(NUM_SLOTS)));
  assert_frame_align_R2: assert property (@(negedge bit_clk) disable iff (!rst_n)
    (bit_vld_i && bit_idx_i == CNT_W'(FRAME_BITS - 1)) |->
      (sb_q == SB_W'(SLOT_W - 1) && sn_q == SNUM_W'(NUM_SLOTS)));
endmodule

// File: rtl/acl_out_frame_rx.sv
module acl_out_frame_rx
  import acl_rx_pkg::*;
#(
  parameter int SLOT_W    = DEF_SLOT_W,
  parameter int NUM_SLOTS = DEF_NUM_SLOTS,
  parameter int HDR_W     = DEF_HDR_W
) (
  input  logic                           bit_clk,
  input  logic                           rst_n,
  input  logic                           sync_in,
  input  logic                           sdata_in,
  output logic                           slot_stb,
  output logic [$clog2(NUM_SLOTS+1)-1:0] slot_num,
  output logic [SLOT_W-1:0]              slot_word,
  output logic [NUM_SLOTS:0]             frame_tags,
  output logic                           frame_err
);
  localparam int FRAME_BITS = frame_bits(HDR_W, SLOT_W, NUM_SLOTS);
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic             srst_n;
  logic             bit_vld;
  logic [CNT_W-1:0] bit_idx;

  acl_rst_sync u_rst (
    .clk_n  (bit_clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  acl_frame_track #(
    .HDR_W(HDR_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
  ) u_track (
    .bit_clk     (bit_clk),
    .rst_n       (srst_n),
    .sync_i      (sync_in),
    .bit_vld_o   (bit_vld),
    .bit_idx_o   (bit_idx),
    .frame_err_o (frame_err)
  );

  acl_hdr_capture #(
    .HDR_W(HDR_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
  ) u_hdr (
    .bit_clk   (bit_clk),
    .rst_n     (srst_n),
    .bit_vld_i (bit_vld),
    .bit_idx_i (bit_idx),
    .sdata_i   (sdata_in),
    .tags_o    (frame_tags)
  );

  acl_slot_deser #(
    .HDR_W(HDR_W), .SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)
  ) u_deser (
    .bit_clk     (bit_clk),
    .rst_n       (srst_n),
    .bit_vld_i   (bit_vld),
    .bit_idx_i   (bit_idx),
    .sdata_i     (sdata_in),
    .tags_i      (frame_tags),
    .slot_stb_o  (slot_stb),
    .slot_num_o  (slot_num),
    .slot_word_o (slot_word)
  );
endmodule

// File: tb/acl_out_frame_rx_tb.sv
module acl_out_frame_rx_tb;
  localparam int NS = 12;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        sync_in;
  logic        sdata_in;
  logic        slot_stb;
  logic [3:0]  slot_num;
  logic [19:0] slot_word;
  logic [12:0] frame_tags;
  logic        frame_err;

  always #4 clk = ~clk;

  acl_out_frame_rx u_dut (
    .bit_clk(clk), .rst_n(rst_n), .sync_in(sync_in), .sdata_in(sdata_in),
    .slot_stb(slot_stb), .slot_num(slot_num), .slot_word(slot_word),
    .frame_tags(frame_tags), .frame_err(frame_err)
  );

  // vector table: {frame flag + slot tags (13 bits), data seed (16 bits)}
  localparam logic [28:0] VEC [0:6] = '{
    {13'h1FFF, 16'd1}, {13'h0FFF, 16'd2}, {13'h1AAA, 16'd3}, {13'h1555, 16'd4},
    {13'h1800, 16'd5}, {13'h1001, 16'd6}, {13'h1000, 16'd7}
  };

  int n_chk = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  int exp_cnt = 0;
  int err_seen = 0;
  logic        exp_dlv [1:NS];
  logic [19:0] exp_wd  [1:NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [19:0] word_of(input int seed, input int k);
    logic [31:0] v;
    v = 32'(seed) * 32'd40503 + 32'(k) * 32'd977 + 32'(k * k) * 32'd131;
    return v[19:0] ^ 20'hA5C3F;
  endfunction

  function automatic logic bit_of(input logic [12:0] t, input int seed, input int i);
    if (i <= 12) return t[12-i];
    if (i <= 15) return 1'b1;          // ignored header bits driven high
    begin
      logic [19:0] w;
      w = word_of(seed, (i - 16) / 20 + 1);
      return w[19 - (i - 16) % 20];
    end
  endfunction

  // strobes last one full bit period; sample them on the rising edge
  always @(posedge clk) begin
    if (frame_err) err_seen++;
    if (slot_stb) begin
      rx_cnt++;
      if (slot_num < 4'd1 || slot_num > 4'd12) begin
        chk(1'b0, "R4", "slot number", 32'(slot_num), 32'd1);
      end else begin
        chk(exp_dlv[slot_num] == 1'b1, "R5", "strobe for untagged slot", 32'(slot_num), 32'd0);
        chk(slot_word == exp_wd[slot_num], "R4", "slot word",
            32'(slot_word), 32'(exp_wd[slot_num]));
      end
    end
  end

  task automatic settle(input logic [12:0] t, input int seed, input int len);
    chk(rx_cnt == exp_cnt, "R5", "strobes in previous frame", 32'(rx_cnt), 32'(exp_cnt));
    exp_cnt = 0;
    for (int k = 1; k <= NS; k++) begin
      exp_dlv[k] = t[12] && t[12-k] && (15 + 20 * k <= len - 1);
      exp_wd[k]  = word_of(seed, k);
      if (exp_dlv[k]) exp_cnt++;
    end
    rx_cnt = 0;
  endtask

  task automatic idle(input int n, input logic s, input bit toggle);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      sync_in  = s;
      sdata_in = toggle ? ~sdata_in : 1'b1;
    end
  endtask

  task automatic preamble();
    @(posedge clk); #1;
    sync_in  = 1'b1;
    sdata_in = 1'b0;
  endtask

  // len bits of a frame; with chain set the last bit carries the next marker rise
  task automatic run_frame(input logic [12:0] t, input int seed, input int len,
                           input bit chain, input bit err_exp);
    for (int i = 0; i < len; i++) begin
      @(posedge clk); #1;
      if (i == 0) chk(frame_err == err_exp, "R7", "error flag at frame start",
                      32'(frame_err), 32'(err_exp));
      if (i == 20) begin
        chk(frame_tags == t, "R3", "header status", 32'(frame_tags), 32'(t));
        settle(t, seed, len);
      end
      sync_in  = (i < 15) || (chain && i == len - 1);
      sdata_in = bit_of(t, seed, i);
    end
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int err_base;
    for (int k = 1; k <= NS; k++) begin exp_dlv[k] = 1'b0; exp_wd[k] = '0; end
    rst_n = 1'b0; sync_in = 1'b0; sdata_in = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R6: reset state
    chk(slot_stb == 1'b0, "R6", "strobe in reset", 32'(slot_stb), 32'd0);
    chk(frame_tags == 13'h0, "R6", "status in reset", 32'(frame_tags), 32'd0);
    chk(frame_err == 1'b0, "R6", "error in reset", 32'(frame_err), 32'd0);
    rst_n = 1'b1;
    // R6: unframed data with the marker low delivers nothing
    idle(300, 1'b0, 1'b1);
    chk(rx_cnt == 0, "R6", "strobes without frame start", 32'(rx_cnt), 32'd0);
    chk(frame_tags == 13'h0, "R6", "status without frame start", 32'(frame_tags), 32'd0);
    // R1: marker high through reset release is not a start
    rst_n = 1'b0; sync_in = 1'b1;
    repeat (3) @(posedge clk);
    #1; rst_n = 1'b1;
    idle(300, 1'b1, 1'b0);
    chk(rx_cnt == 0, "R1", "strobes with marker stuck high", 32'(rx_cnt), 32'd0);
    chk(frame_tags == 13'h0, "R1", "status with marker stuck high", 32'(frame_tags), 32'd0);
    chk(err_seen == 0, "R1", "errors with marker stuck high", 32'(err_seen), 32'd0);
    idle(4, 1'b0, 1'b1);
    // R2 R3 R4 R5: table of header patterns, frames back to back
    preamble();
    foreach (VEC[v]) run_frame(VEC[v][28:16], int'(VEC[v][15:0]), 256, 1'b1, 1'b0);
    chk(err_seen == 0, "R7", "errors on regular frame boundaries", 32'(err_seen), 32'd0);
    // R7: frame cut short at bit 100, then a full frame after resync
    err_base = err_seen;
    run_frame(13'h1FFF, 11, 101, 1'b1, 1'b0);
    run_frame(13'h1F0F, 12, 256, 1'b0, 1'b1);
    chk(err_seen == err_base + 1, "R7", "error pulses for short frame",
        32'(err_seen), 32'(err_base + 1));
    // R7: start after an idle gap raises no error
    idle(40, 1'b0, 1'b1);
    err_base = err_seen;
    preamble();
    run_frame(13'h1FFF, 13, 256, 1'b0, 1'b0);
    // R8: after the frame ends, more data issues nothing
    idle(300, 1'b0, 1'b1);
    settle(13'h0000, 0, 0);
    chk(frame_tags == 13'h1FFF, "R8", "status held while idle", 32'(frame_tags), 32'h1FFF);
    chk(err_seen == err_base, "R7", "error after idle gap", 32'(err_seen), 32'(err_base));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule